// File: doc/BRIEF.md
# Bit-Serial Framed Receiver with Check-Octet Capture

This block receives a bit-serial, flag-delimited frame stream, one bit per strobe of a recovered-clock enable. It searches the line for flag octets and deletes the zeros that a transmitter inserts after five ones. It assembles the remaining bits least-significant first into octets and places each octet in a small receive queue. Every queue entry carries an end-of-frame marker. A run of seven ones aborts the frame in progress, and the receiver then waits for the next flag.

Received bits pass through a nine-bit holding line before byte assembly, because a flag is only known once its last bit has arrived. When the closing flag is recognised, the two newest frame bits are still in that holding line. With the bit-oriented mode selected, those two bits are merged into the last entry, so all sixteen bits of the trailing check field reach the queue and software can inspect or resend them. With the generic byte-synchronous mode selected, the two bits are not stored. No configuration bit controls this capture. Software drains the queue through a simple valid/pop pair. A sticky flag reports that an octet arrived while the queue was full.

Top module: `sdlc_rx_capture`

## Requirements
- R1: After reset the queue is empty (`rd_valid` low) and `overrun` is low.
- R2: A flag is the bit sequence 0,1,1,1,1,1,1,0 in time order, and it opens a frame. While no frame is open, line bits never produce queue entries.
- R3: Inside a frame, a 0 that follows exactly five consecutive ones is deleted and does not count as a frame bit.
- R4: Frame bits fill each octet from bit 0 upward. Each completed octet that is not the last of its frame is queued with end-of-frame (`rd_eof`) 0.
- R5: With `sdlc_mode` = 1, the closing flag queues the final octet, including its two newest bits, with `rd_eof` = 1. Every bit of a two-octet check field is therefore delivered.
- R6: With `sdlc_mode` = 0, the closing flag queues the final entry with `rd_eof` = 1, but the two newest frame bits are not stored. For octet-aligned frames, bits 7 and 6 of that entry read 0.
- R7: Seven consecutive ones abort the open frame. Its unqueued bits are discarded, and nothing is queued until a later flag.
- R8: One flag may close a frame and open the next. Consecutive flags with no frame bits between them produce no entry.
- R9: The queue holds 4 entries and returns them in arrival order. `rd_valid` is high while it is not empty, and a cycle with `rd_en` and `rd_valid` both high removes the head.
- R10: An entry that arrives when the queue is full and not being popped is dropped, and `overrun` goes high. `overrun` returns low after the next pop that coincides with no dropped entry.
- R11: `rxd` is sampled only in cycles where `rx_en` is high. Line values in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Bit strobe from clock recovery |
| rxd | input | 1 | Serial line data |
| sdlc_mode | input | 1 | 1 = bit-oriented mode with residual capture, 0 = generic byte-synchronous |
| rd_en | input | 1 | Pop the queue head |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Octet at the queue head |
| rd_eof | output | 1 | Head entry closes a frame |
| overrun | output | 1 | Sticky: an entry was dropped on a full queue |

## Verification
The bench builds the block with its default parameters: 8-bit octets, a 4-entry queue, a five-ones stuffing run and a two-bit residual. With the 4-entry queue, a six-octet frame received while reads are held back overfills it, which makes the drop path and the sticky flag reachable. The 8-bit octet size keeps the residual-merge boundary at bit 6, where both modes can be compared on the same final octet. Stuffing-heavy octets, shared and idle flags, an abort in mid-frame, and line noise between strobes are all driven against a queue of expected entries.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;

  // Classification of one received line bit
  typedef enum logic [1:0] {
    SYM_DATA  = 2'd0,
    SYM_STUFF = 2'd1,
    SYM_FLAG  = 2'd2,
    SYM_ABORT = 2'd3
  } sym_e;

endpackage

// File: rtl/sdlc_rx_linedec.sv
module sdlc_rx_linedec
  import sdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output sym_e sym
);

  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int CNT_W     = $clog2(ABORT_RUN + 1);

  logic [CNT_W-1:0] ones_q, ones_d;

  always_comb begin
    ones_d = ones_q;
    sym    = SYM_DATA;
    if (bit_in) begin
      if (ones_q >= CNT_W'(FLAG_RUN)) sym = SYM_ABORT;
      if (ones_q != CNT_W'(ABORT_RUN)) ones_d = ones_q + CNT_W'(1);
    end else begin
      if (ones_q == CNT_W'(FLAG_RUN))       sym = SYM_FLAG;
      else if (ones_q == CNT_W'(STUFF_RUN)) sym = SYM_STUFF;
      ones_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ones_q <= '0;
    else if (bit_en) ones_q <= ones_d;
  end

  AST_STUFF_RESETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sym == SYM_STUFF) |=> (ones_q == '0)); // R3

endmodule

// File: rtl/sdlc_rx_framer.sv
module sdlc_rx_framer
  import sdlc_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int RESID  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  sym_e              sym,
  input  logic              sdlc_mode,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_eof
);

  localparam int HOLD_W = FLAG_W - 1 + RESID;
  localparam int HCNT_W = $clog2(HOLD_W + 1);
  localparam int BCNT_W = $clog2(DATA_W);

  logic              in_frame_q, in_frame_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic [DATA_W-1:0] asm_q, asm_d, asm_nxt, fin;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  int                resid_n;

  always_comb begin
    in_frame_d = in_frame_q;
    hold_d     = hold_q;
    hcnt_d     = hcnt_q;
    asm_d      = asm_q;
    bcnt_d     = bcnt_q;
    asm_nxt    = asm_q;
    push       = 1'b0;
    push_data  = '0;
    push_eof   = 1'b0;
    resid_n    = int'(hcnt_q) - (FLAG_W - 1);
    fin        = asm_q;
    if (sdlc_mode) begin
      for (int i = 0; i < RESID; i++) begin
        if (i < resid_n && int'(bcnt_q) + i < DATA_W)
          fin[int'(bcnt_q) + i] = hold_q[FLAG_W - 2 + resid_n - i];
      end
    end
    if (bit_en) begin
      case (sym)
        SYM_FLAG: begin
          if (in_frame_q && resid_n > 0) begin
            push      = 1'b1;
            push_data = fin;
            push_eof  = 1'b1;
          end
          in_frame_d = 1'b1;
          hold_d     = '0;
          hcnt_d     = '0;
          asm_d      = '0;
          bcnt_d     = '0;
        end
        SYM_ABORT: begin
          in_frame_d = 1'b0;
          hold_d     = '0;
          hcnt_d     = '0;
          asm_d      = '0;
          bcnt_d     = '0;
        end
        SYM_DATA: begin
          if (in_frame_q) begin
            hold_d = {hold_q[HOLD_W-2:0], bit_in};
            if (hcnt_q == HCNT_W'(HOLD_W)) begin
              asm_nxt[bcnt_q] = hold_q[HOLD_W-1];
              if (bcnt_q == BCNT_W'(DATA_W - 1)) begin
                push      = 1'b1;
                push_data = asm_nxt;
                asm_d     = '0;
                bcnt_d    = '0;
              end else begin
                asm_d  = asm_nxt;
                bcnt_d = bcnt_q + BCNT_W'(1);
              end
            end else begin
              hcnt_d = hcnt_q + HCNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      hold_q     <= '0;
      hcnt_q     <= '0;
      asm_q      <= '0;
      bcnt_q     <= '0;
    end else if (bit_en) begin
      in_frame_q <= in_frame_d;
      hold_q     <= hold_d;
      hcnt_q     <= hcnt_d;
      asm_q      <= asm_d;
      bcnt_q     <= bcnt_d;
    end
  end

  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame_q |-> !push); // R2

  AST_SDLC_CLOSE_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sym == SYM_FLAG && in_frame_q && sdlc_mode && hcnt_q == HCNT_W'(HOLD_W))
      |-> (push && push_eof)); // R5

  AST_SYNC_DROPS_RESID: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sym == SYM_FLAG && in_frame_q && !sdlc_mode && hcnt_q == HCNT_W'(HOLD_W)
      && bcnt_q == BCNT_W'(DATA_W - RESID))
      |-> (push && push_data[DATA_W-1 -: RESID] == '0)); // R6

  AST_ABORT_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sym == SYM_ABORT) |=> !in_frame_q); // R7

  AST_MID_OCTET_NO_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && sym == SYM_DATA && push) |-> !push_eof); // R4

endmodule

// File: rtl/sdlc_rx_fifo.sv
module sdlc_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_eof,
  input  logic              pop,
  output logic              head_valid,
  output logic [DATA_W-1:0] head_data,
  output logic              head_eof,
  output logic              overrun
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W:0]   mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovr_q, ovr_d;
  logic              full, pop_ok, accept, drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    full     = (cnt_q == CNT_W'(DEPTH));
    pop_ok   = pop && (cnt_q != '0);
    accept   = push && (!full || pop_ok);
    drop     = push && !accept;
    wr_ptr_d = accept ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (accept && !pop_ok)      cnt_d = cnt_q + CNT_W'(1);
    else if (!accept && pop_ok) cnt_d = cnt_q - CNT_W'(1);
    ovr_d = drop ? 1'b1 : (pop_ok ? 1'b0 : ovr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovr_q    <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr_q] <= {push_eof, push_data};
  end

  assign head_valid = (cnt_q != '0);
  assign head_data  = mem[rd_ptr_q][DATA_W-1:0];
  assign head_eof   = mem[rd_ptr_q][DATA_W];
  assign overrun    = ovr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (overrun && cnt_q == CNT_W'(DEPTH))); // R10

  AST_POP_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_valid && !push) |=> !overrun); // R10

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(cnt_q)); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R9

endmodule

// File: rtl/sdlc_rx_capture.sv
module sdlc_rx_capture
  import sdlc_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4,
  parameter int STUFF_RUN = 5,
  parameter int RESID     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic              sdlc_mode,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eof,
  output logic              overrun
);

  localparam int FLAG_W = STUFF_RUN + 3;

  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  sym_e              sym;
  logic              push, push_eof;
  logic [DATA_W-1:0] push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  sdlc_rx_linedec #(.STUFF_RUN(STUFF_RUN)) u_linedec (
    .clk    (clk),
    .rst_n  (rst_ns),
    .bit_en (rx_en),
    .bit_in (rxd),
    .sym    (sym)
  );

  sdlc_rx_framer #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .RESID(RESID)) u_framer (
    .clk       (clk),
    .rst_n     (rst_ns),
    .bit_en    (rx_en),
    .bit_in    (rxd),
    .sym       (sym),
    .sdlc_mode (sdlc_mode),
    .push      (push),
    .push_data (push_data),
    .push_eof  (push_eof)
  );

  sdlc_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_ns),
    .push       (push),
    .push_data  (push_data),
    .push_eof   (push_eof),
    .pop        (rd_en),
    .head_valid (rd_valid),
    .head_data  (rd_data),
    .head_eof   (rd_eof),
    .overrun    (overrun)
  );

endmodule

// File: tb/sdlc_rx_capture_tb.sv
module sdlc_rx_capture_tb;

  logic       clk;
  logic       rst_n, rx_en, rxd, sdlc_mode, rd_en;
  logic       rd_valid, rd_eof, overrun;
  logic [7:0] rd_data;

  logic [8:0] exp_q[$];
  int         tests, fails, tb_ones, gap;
  bit         hold_reads, done;
  string      cur_req;

  sdlc_rx_capture u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd), .sdlc_mode(sdlc_mode),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eof(rd_eof),
    .overrun(overrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops queue entries and compares against the scoreboard
  initial rd_en = 1'b0;
  always @(negedge clk) begin
    if (rd_en) rd_en = 1'b0;
    else if (rst_n && rd_valid && !hold_reads) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL %s: unexpected entry actual %h expected none", cur_req, {rd_eof, rd_data});
      end else begin
        chk(cur_req, {rd_eof, rd_data}, exp_q.pop_front());
      end
      rd_en = 1'b1;
    end
  end

  task automatic drive_raw(input logic b);
    @(negedge clk);
    rx_en = 1'b1; rxd = b;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      rx_en = 1'b0; rxd = ~rxd;
    end
  endtask

  task automatic send_flag();
    drive_raw(1'b0);
    for (int i = 0; i < 6; i++) drive_raw(1'b1);
    drive_raw(1'b0);
    tb_ones = 0;
  endtask

  task automatic send_bit(input logic b);
    drive_raw(b);
    if (b) begin
      tb_ones++;
      if (tb_ones == 5) begin drive_raw(1'b0); tb_ones = 0; end
    end else tb_ones = 0;
  endtask

  task automatic send_octet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  // Driver: sends a whole frame and queues the expected entries
  task automatic send_frame(input logic [7:0] pl[$], input bit sdlc);
    for (int i = 0; i < pl.size(); i++) begin
      if (i == pl.size() - 1) exp_q.push_back({1'b1, sdlc ? pl[i] : (pl[i] & 8'h3F)});
      else                    exp_q.push_back({1'b0, pl[i]});
    end
    send_flag();
    foreach (pl[i]) send_octet(pl[i]);
    send_flag();
  endtask

  task automatic drain(input string req);
    repeat (40) @(negedge clk);
    chk(req, 9'(exp_q.size()), 9'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] pl[$];
    tests = 0; fails = 0; tb_ones = 0; gap = 1; done = 1'b0;
    hold_reads = 1'b0; cur_req = "R1";
    rst_n = 1'b0; rx_en = 1'b0; rxd = 1'b1; sdlc_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {8'd0, rd_valid}, 9'd0);
    chk("R1", {8'd0, overrun}, 9'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {8'd0, rd_valid}, 9'd0);

    // R2: line noise while hunting, including a five-ones run, queues nothing
    cur_req = "R2";
    foreach (pl[i]) ;
    drive_raw(1); drive_raw(0); drive_raw(1); drive_raw(1); drive_raw(0); drive_raw(0);
    for (int i = 0; i < 5; i++) drive_raw(1'b1);
    drive_raw(0); drive_raw(1); drive_raw(0);
    repeat (10) @(negedge clk);
    chk("R2", {8'd0, rd_valid}, 9'd0);

    // R4/R5: octets least-significant first, full check field delivered
    cur_req = "R4/R5";
    pl = '{8'hA5, 8'h3C, 8'h12, 8'hC7};
    send_frame(pl, 1'b1);
    drain("R5");

    // R3: stuffing-heavy payload
    cur_req = "R3";
    pl = '{8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'hFF};
    send_frame(pl, 1'b1);
    drain("R3");

    // R6: byte-synchronous mode drops the two newest bits
    cur_req = "R6";
    sdlc_mode = 1'b0;
    pl = '{8'h11, 8'hC3, 8'hFF};
    send_frame(pl, 1'b0);
    drain("R6");
    pl = '{8'h9A, 8'h80};
    send_frame(pl, 1'b0);
    drain("R6");
    sdlc_mode = 1'b1;

    // R8: idle flags then frames sharing a flag
    cur_req = "R8";
    send_flag(); send_flag(); send_flag();
    repeat (10) @(negedge clk);
    chk("R8", {8'd0, rd_valid}, 9'd0);
    exp_q.push_back({1'b1, 8'h55});
    exp_q.push_back({1'b0, 8'h66});
    exp_q.push_back({1'b1, 8'h77});
    send_octet(8'h55); send_flag();
    send_octet(8'h66); send_octet(8'h77); send_flag();
    drain("R8");

    // R7: abort mid-frame discards, next frame received
    cur_req = "R7";
    send_flag();
    send_octet(8'h00);
    for (int i = 0; i < 10; i++) drive_raw(1'b1);
    tb_ones = 0;
    repeat (20) @(negedge clk);
    chk("R7", {8'd0, rd_valid}, 9'd0);
    pl = '{8'h5A};
    send_frame(pl, 1'b1);
    drain("R7");

    // R11: wide gaps full of line noise between strobes
    cur_req = "R11";
    gap = 3;
    pl = '{8'hE1, 8'h0F, 8'hB6};
    send_frame(pl, 1'b1);
    drain("R11");
    gap = 1;

    // R9/R10: overfill the 4-entry queue with reads held back
    hold_reads = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R9/R10";
    send_flag();
    for (int i = 1; i <= 6; i++) send_octet(8'(i));
    send_flag();
    repeat (4) @(negedge clk);
    chk("R10", {8'd0, overrun}, 9'd1);
    chk("R9", {8'd0, rd_valid}, 9'd1);
    for (int i = 1; i <= 4; i++) exp_q.push_back({1'b0, 8'(i)});
    hold_reads = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", {8'd0, overrun}, 9'd0);
    drain("R9");
    chk("R9", {8'd0, rd_valid}, 9'd0);

    finish_run();
  end

endmodule